// File: doc/BRIEF.md
# Display Bridge Power-Up Sequencer

This block brings a parallel-to-serial display bridge out of reset and into video streaming with no processor involved. After its own reset it holds the bridge's reset pin low for a programmed number of milliseconds, releases it, and waits the same time again. If the board can read registers back, it then checks the bridge's identity word and the power-on value of its configuration word. Next it writes the panel's sync, porch and active-area timing, the pixel format, the lane count, a first configuration word, the PLL settings and the low-power clock divider. It starts the PLL, waits for lock, and sends the two panel commands that wake the panel and switch the display on, with a programmable pause after each. Last, it rewrites the configuration word with high-speed data lanes and the video pipeline turned on.

All register traffic goes through a register access master that runs the serial link. The sequencer raises a request with an address, a direction and a 16-bit write word, holds them, and waits for a one-cycle done pulse that also carries read data. Every wait comes from one prescaled timer: `CYCLES_PER_US` clock cycles per microsecond and `US_PER_MS` microseconds per millisecond. The sequence ends in one of two lasting outcomes. `ready` means the bridge is streaming. `error` means a read-back mismatch or a colour depth the bridge cannot carry.

Top module: `dispbridge_bringup`

## Requirements
- R1: After reset, `bridge_rst_n` is low for `RST_MS` milliseconds. It then goes high, and no register request appears for a further `RST_MS` milliseconds. No request is ever raised while `bridge_rst_n` is low.
- R2: With `verify_en` high, the first two transfers are reads of address 0xB0 and then 0xB7. A read of 0xB0 returning anything but 0x2828, or a read of 0xB7 returning anything but 0x0301, ends the sequence in `error` with no further requests. With `verify_en` low, no read is issued.
- R3: The timing writes come next, in this order. 0xB1 gets {vsync, hsync}. 0xB2 gets {vsync+vback, hsync+hback}, each byte taken modulo 256. 0xB3 gets {vfront, hfront}. 0xB4 gets the active width and 0xB5 the active height. In each pair the first value is the upper byte.
- R4: 0xB6 is written with 0b10 in bits 3:2 (burst mode), a format code in bits 1:0 and zeros above. The format code is 0 for depth 16 (`loose_pack` ignored), 1 for depth 18 packed, 2 for depth 18 with `loose_pack`=1, and 3 for depth 24 (`loose_pack` ignored). Any other depth ends in `error` right after the 0xB5 write, and 0xB6 is never written.
- R5: 0xDE is written with `lane_count` − 1.
- R6: 0xB7 is then written with 0x0342, or 0x0362 when `pclk_ref` is 1. That is the power-on word 0x0301 with bit 0 cleared, bits 1 and 6 set, and bit 5 equal to `pclk_ref`.
- R7: Next come 0xBA = `pll_word`, 0xB8 = 0, 0xBB = `lp_div` zero-extended and 0xB9 = 1. The next request comes no sooner than `LOCK_US` microseconds after the 0xB9 write completes.
- R8: Each panel command is a write of 1 to 0xBC followed by a write of the command byte to 0xBF. First 0x11 is sent, followed by a pause of `sleep_delay_ms` ms. Then 0x29 is sent, followed by a pause of `on_delay_ms` ms. A zero delay gives no pause.
- R9: The final write is the R6 word with bits 0 and 3 also set, sent to 0xB7. After it completes, `ready` goes high and stays high until reset, and no further request is issued.
- R10: `reg_req` stays high, with `reg_addr`, `reg_we` and `reg_wdata` unchanged, until `reg_done` is seen. A done pulse completes exactly one transfer.
- R11: `ready` and `error` are never high together. Each stays high until reset once it is set, and both are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| verify_en | input | 1 | Read-back path present: check identity and power-on configuration |
| pclk_ref | input | 1 | PLL reference is the pixel clock (sets configuration bit 5) |
| hsync_len | input | 8 | Horizontal sync width |
| vsync_len | input | 8 | Vertical sync width |
| hback_len | input | 8 | Horizontal back porch |
| vback_len | input | 8 | Vertical back porch |
| hfront_len | input | 8 | Horizontal front porch |
| vfront_len | input | 8 | Vertical front porch |
| h_active | input | 16 | Active pixels per line |
| v_active | input | 16 | Active lines per frame |
| color_depth | input | 5 | Bits per pixel: 16, 18 or 24 |
| loose_pack | input | 1 | Loose packing for 18-bit pixels |
| lane_count | input | LANE_W | Number of serial data lanes |
| pll_word | input | 16 | PLL configuration word |
| lp_div | input | DIV_W | Low-power clock divider field |
| sleep_delay_ms | input | DLY_W | Pause after the wake command, ms |
| on_delay_ms | input | DLY_W | Pause after the display-on command, ms |
| reg_req | output | 1 | Register transfer request, held until done |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Register address |
| reg_wdata | output | 16 | Write data |
| reg_done | input | 1 | One-cycle completion of the current transfer |
| reg_rdata | input | 16 | Read data, valid with reg_done |
| bridge_rst_n | output | 1 | Reset pin of the bridge, active low |
| ready | output | 1 | Bring-up complete, video running |
| error | output | 1 | Bring-up aborted |

## Verification
The bench targets the format decode: both 18-bit packings, a 16-bit and a 24-bit request with the loose flag set, and an unsupported depth. A decoder that honoured the flag for the wrong depth would put the wrong code into 0xB6. One that caught a bad depth too late or too early would write 0xB6 anyway or drop the timing writes. The porch sums are driven past 255 to catch a carry leaking into the neighbouring byte. Each read-back mismatch is forced separately, so a sequencer that ignored one of the two compares would go on writing. The reset pulse, the lock wait and a zero-length command pause are measured in cycles at the register interface, to expose a timer that counts the wrong unit or sticks on a zero load.

// File: rtl/dispbridge_pkg.sv
package dispbridge_pkg;

  localparam int REG_AW  = 8;
  localparam int REG_DW  = 16;
  localparam int FLD_W   = REG_DW / 2;
  localparam int DEPTH_W = 5;
  localparam int STEP_W  = 5;

  // register addresses on the bridge
  localparam logic [REG_AW-1:0] A_IDENT   = 8'hB0;
  localparam logic [REG_AW-1:0] A_SYNC    = 8'hB1;
  localparam logic [REG_AW-1:0] A_BPORCH  = 8'hB2;
  localparam logic [REG_AW-1:0] A_FPORCH  = 8'hB3;
  localparam logic [REG_AW-1:0] A_HACT    = 8'hB4;
  localparam logic [REG_AW-1:0] A_VACT    = 8'hB5;
  localparam logic [REG_AW-1:0] A_VMODE   = 8'hB6;
  localparam logic [REG_AW-1:0] A_CFG     = 8'hB7;
  localparam logic [REG_AW-1:0] A_VCHAN   = 8'hB8;
  localparam logic [REG_AW-1:0] A_PLLON   = 8'hB9;
  localparam logic [REG_AW-1:0] A_PLLSET  = 8'hBA;
  localparam logic [REG_AW-1:0] A_CLKDIV  = 8'hBB;
  localparam logic [REG_AW-1:0] A_PKTLEN  = 8'hBC;
  localparam logic [REG_AW-1:0] A_PKTDATA = 8'hBF;
  localparam logic [REG_AW-1:0] A_LANES   = 8'hDE;

  localparam logic [REG_DW-1:0] IDENT_VAL = 16'h2828;
  localparam logic [REG_DW-1:0] CFG_POR   = 16'h0301;

  // configuration word bit positions
  localparam int CFGB_HSDATA  = 0;
  localparam int CFGB_CLKHS   = 1;
  localparam int CFGB_VIDEN   = 3;
  localparam int CFGB_PCLKREF = 5;
  localparam int CFGB_CMDONLY = 6;

  localparam logic [1:0] MODE_BURST = 2'b10;

  localparam logic [FLD_W-1:0] CMD_WAKE    = 8'h11;
  localparam logic [FLD_W-1:0] CMD_DISP_ON = 8'h29;

  // write steps with a special follow-up
  localparam logic [STEP_W-1:0] STEP_FMT  = 5'd5;
  localparam logic [STEP_W-1:0] STEP_LOCK = 5'd11;
  localparam logic [STEP_W-1:0] STEP_WAKE = 5'd13;
  localparam logic [STEP_W-1:0] STEP_DISP = 5'd15;
  localparam logic [STEP_W-1:0] STEP_LAST = 5'd16;

  typedef enum logic [3:0] {
    SQ_BOOT,
    SQ_RST_LO,
    SQ_RST_HI,
    SQ_RD_ID,
    SQ_RD_CFG,
    SQ_WRITE,
    SQ_PAUSE,
    SQ_READY,
    SQ_FAIL
  } seq_state_t;

endpackage

// File: rtl/dispbridge_waiter.sv
module dispbridge_waiter #(
  parameter int CYCLES_PER_US = 100,
  parameter int US_PER_MS     = 1000,
  parameter int AMT_W         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             unit_ms,
  input  logic [AMT_W-1:0] amount,
  output logic             expired
);

  localparam int CYC_W = (CYCLES_PER_US > 1) ? $clog2(CYCLES_PER_US) : 1;
  localparam int SUB_W = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYCLES_PER_US - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(US_PER_MS - 1);

  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [AMT_W-1:0] rem_q, rem_d;
  logic             ms_q, ms_d;
  logic             running, us_tick, ms_tick, unit_tick, en;

  assign running   = (rem_q != '0);
  assign us_tick   = running && (cyc_q == CYC_LAST);
  assign ms_tick   = us_tick && (sub_q == SUB_LAST);
  assign unit_tick = ms_q ? ms_tick : us_tick;
  assign en        = load || running;
  assign expired   = !running;

  always_comb begin
    cyc_d = cyc_q;
    sub_d = sub_q;
    rem_d = rem_q;
    ms_d  = ms_q;
    if (load) begin
      cyc_d = '0;
      sub_d = '0;
      rem_d = amount;
      ms_d  = unit_ms;
    end else if (running) begin
      cyc_d = us_tick ? '0 : cyc_q + 1'b1;
      if (us_tick) begin
        sub_d = (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
      end
      if (unit_tick) begin
        rem_d = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      sub_q <= '0;
      rem_q <= '0;
      ms_q  <= 1'b0;
    end else if (en) begin
      cyc_q <= cyc_d;
      sub_q <= sub_d;
      rem_q <= rem_d;
      ms_q  <= ms_d;
    end
  end

endmodule

// File: rtl/dispbridge_step_rom.sv
module dispbridge_step_rom
  import dispbridge_pkg::*;
#(
  parameter int LANE_W = 3,
  parameter int DIV_W  = 6
) (
  input  logic [STEP_W-1:0]  step,
  input  logic               pclk_ref,
  input  logic [FLD_W-1:0]   hsync_len,
  input  logic [FLD_W-1:0]   vsync_len,
  input  logic [FLD_W-1:0]   hback_len,
  input  logic [FLD_W-1:0]   vback_len,
  input  logic [FLD_W-1:0]   hfront_len,
  input  logic [FLD_W-1:0]   vfront_len,
  input  logic [REG_DW-1:0]  h_active,
  input  logic [REG_DW-1:0]  v_active,
  input  logic [DEPTH_W-1:0] color_depth,
  input  logic               loose_pack,
  input  logic [LANE_W-1:0]  lane_count,
  input  logic [REG_DW-1:0]  pll_word,
  input  logic [DIV_W-1:0]   lp_div,
  output logic [REG_AW-1:0]  addr,
  output logic [REG_DW-1:0]  data,
  output logic               fmt_bad
);

  logic [1:0]        fmt_code;
  logic              fmt_ok;
  logic [FLD_W-1:0]  vsum, hsum;
  logic [REG_DW-1:0] cfg_cmd, cfg_run;

  always_comb begin
    fmt_ok   = 1'b1;
    fmt_code = 2'd0;
    unique case (color_depth)
      5'd16:   fmt_code = 2'd0;
      5'd18:   fmt_code = loose_pack ? 2'd2 : 2'd1;
      5'd24:   fmt_code = 2'd3;
      default: fmt_ok   = 1'b0;
    endcase
  end

  assign vsum = vsync_len + vback_len;
  assign hsum = hsync_len + hback_len;

  always_comb begin
    cfg_cmd = CFG_POR;
    cfg_cmd[CFGB_HSDATA]  = 1'b0;
    cfg_cmd[CFGB_CLKHS]   = 1'b1;
    cfg_cmd[CFGB_CMDONLY] = 1'b1;
    cfg_cmd[CFGB_PCLKREF] = pclk_ref;
    cfg_run = cfg_cmd;
    cfg_run[CFGB_HSDATA]  = 1'b1;
    cfg_run[CFGB_VIDEN]   = 1'b1;
  end

  assign fmt_bad = (step == STEP_FMT) && !fmt_ok;

  always_comb begin
    addr = A_SYNC;
    data = '0;
    case (step)
      5'd0:  begin addr = A_SYNC;    data = {vsync_len, hsync_len};   end
      5'd1:  begin addr = A_BPORCH;  data = {vsum, hsum};             end
      5'd2:  begin addr = A_FPORCH;  data = {vfront_len, hfront_len}; end
      5'd3:  begin addr = A_HACT;    data = h_active;                 end
      5'd4:  begin addr = A_VACT;    data = v_active;                 end
      5'd5:  begin addr = A_VMODE;   data = {12'd0, MODE_BURST, fmt_code}; end
      5'd6:  begin addr = A_LANES;   data = REG_DW'(lane_count) - 16'd1;   end
      5'd7:  begin addr = A_CFG;     data = cfg_cmd;                  end
      5'd8:  begin addr = A_PLLSET;  data = pll_word;                 end
      5'd9:  begin addr = A_VCHAN;   data = '0;                       end
      5'd10: begin addr = A_CLKDIV;  data = REG_DW'(lp_div);          end
      5'd11: begin addr = A_PLLON;   data = 16'd1;                    end
      5'd12: begin addr = A_PKTLEN;  data = 16'd1;                    end
      5'd13: begin addr = A_PKTDATA; data = {8'd0, CMD_WAKE};         end
      5'd14: begin addr = A_PKTLEN;  data = 16'd1;                    end
      5'd15: begin addr = A_PKTDATA; data = {8'd0, CMD_DISP_ON};      end
      5'd16: begin addr = A_CFG;     data = cfg_run;                  end
      default: begin addr = A_SYNC;  data = '0;                       end
    endcase
  end

endmodule

// File: rtl/dispbridge_ctrl.sv
module dispbridge_ctrl
  import dispbridge_pkg::*;
#(
  parameter int RST_MS   = 10,
  parameter int LOCK_US  = 500,
  parameter int WAIT_W   = 16,
  parameter int DLY_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              verify_en,
  input  logic [DLY_W-1:0]  sleep_delay_ms,
  input  logic [DLY_W-1:0]  on_delay_ms,
  input  logic [REG_AW-1:0] rom_addr,
  input  logic [REG_DW-1:0] rom_data,
  input  logic              fmt_bad,
  input  logic              reg_done,
  input  logic [REG_DW-1:0] reg_rdata,
  input  logic              wait_expired,
  output logic [STEP_W-1:0] step,
  output logic              wait_load,
  output logic              wait_unit_ms,
  output logic [WAIT_W-1:0] wait_amount,
  output logic              reg_req,
  output logic              reg_we,
  output logic [REG_AW-1:0] reg_addr,
  output logic [REG_DW-1:0] reg_wdata,
  output logic              bridge_rst_n,
  output logic              ready,
  output logic              error
);

  localparam logic [WAIT_W-1:0] RST_AMT  = WAIT_W'(RST_MS);
  localparam logic [WAIT_W-1:0] LOCK_AMT = WAIT_W'(LOCK_US);

  seq_state_t        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              state_en;

  always_comb begin
    state_d      = state_q;
    step_d       = step_q;
    wait_load    = 1'b0;
    wait_unit_ms = 1'b1;
    wait_amount  = '0;
    case (state_q)
      SQ_BOOT: begin
        wait_load   = 1'b1;
        wait_amount = RST_AMT;
        state_d     = SQ_RST_LO;
      end
      SQ_RST_LO: begin
        if (wait_expired) begin
          wait_load   = 1'b1;
          wait_amount = RST_AMT;
          state_d     = SQ_RST_HI;
        end
      end
      SQ_RST_HI: begin
        if (wait_expired) begin
          step_d  = '0;
          state_d = verify_en ? SQ_RD_ID : SQ_WRITE;
        end
      end
      SQ_RD_ID: begin
        if (reg_done) begin
          state_d = (reg_rdata == IDENT_VAL) ? SQ_RD_CFG : SQ_FAIL;
        end
      end
      SQ_RD_CFG: begin
        if (reg_done) begin
          step_d  = '0;
          state_d = (reg_rdata == CFG_POR) ? SQ_WRITE : SQ_FAIL;
        end
      end
      SQ_WRITE: begin
        if (fmt_bad) begin
          state_d = SQ_FAIL;
        end else if (reg_done) begin
          if (step_q == STEP_LOCK) begin
            wait_load    = 1'b1;
            wait_unit_ms = 1'b0;
            wait_amount  = LOCK_AMT;
            state_d      = SQ_PAUSE;
          end else if (step_q == STEP_WAKE) begin
            wait_load   = 1'b1;
            wait_amount = WAIT_W'(sleep_delay_ms);
            state_d     = SQ_PAUSE;
          end else if (step_q == STEP_DISP) begin
            wait_load   = 1'b1;
            wait_amount = WAIT_W'(on_delay_ms);
            state_d     = SQ_PAUSE;
          end else if (step_q == STEP_LAST) begin
            state_d = SQ_READY;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
      end
      SQ_PAUSE: begin
        if (wait_expired) begin
          step_d  = step_q + 1'b1;
          state_d = SQ_WRITE;
        end
      end
      SQ_READY: state_d = SQ_READY;
      SQ_FAIL:  state_d = SQ_FAIL;
      default:  state_d = SQ_FAIL;
    endcase
  end

  assign state_en = (state_d != state_q) || (step_d != step_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_BOOT;
      step_q  <= '0;
    end else if (state_en) begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign step         = step_q;
  assign bridge_rst_n = (state_q != SQ_BOOT) && (state_q != SQ_RST_LO);
  assign ready        = (state_q == SQ_READY);
  assign error        = (state_q == SQ_FAIL);
  assign reg_req      = (state_q == SQ_RD_ID) || (state_q == SQ_RD_CFG) ||
                        ((state_q == SQ_WRITE) && !fmt_bad);
  assign reg_we       = (state_q == SQ_WRITE);

  always_comb begin
    reg_addr  = rom_addr;
    reg_wdata = '0;
    if (state_q == SQ_RD_ID) begin
      reg_addr = A_IDENT;
    end else if (state_q == SQ_RD_CFG) begin
      reg_addr = A_CFG;
    end else if (state_q == SQ_WRITE) begin
      reg_wdata = rom_data;
    end
  end

endmodule

// File: rtl/dispbridge_bringup.sv
module dispbridge_bringup
  import dispbridge_pkg::*;
#(
  parameter int CYCLES_PER_US = 100,
  parameter int US_PER_MS     = 1000,
  parameter int RST_MS        = 10,
  parameter int LOCK_US       = 500,
  parameter int WAIT_W        = 16,
  parameter int LANE_W        = 3,
  parameter int DIV_W         = 6,
  parameter int DLY_W         = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               verify_en,
  input  logic               pclk_ref,
  input  logic [7:0]         hsync_len,
  input  logic [7:0]         vsync_len,
  input  logic [7:0]         hback_len,
  input  logic [7:0]         vback_len,
  input  logic [7:0]         hfront_len,
  input  logic [7:0]         vfront_len,
  input  logic [15:0]        h_active,
  input  logic [15:0]        v_active,
  input  logic [4:0]         color_depth,
  input  logic               loose_pack,
  input  logic [LANE_W-1:0]  lane_count,
  input  logic [15:0]        pll_word,
  input  logic [DIV_W-1:0]   lp_div,
  input  logic [DLY_W-1:0]   sleep_delay_ms,
  input  logic [DLY_W-1:0]   on_delay_ms,
  output logic               reg_req,
  output logic               reg_we,
  output logic [7:0]         reg_addr,
  output logic [15:0]        reg_wdata,
  input  logic               reg_done,
  input  logic [15:0]        reg_rdata,
  output logic               bridge_rst_n,
  output logic               ready,
  output logic               error
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [STEP_W-1:0] step;
  logic [REG_AW-1:0] rom_addr;
  logic [REG_DW-1:0] rom_data;
  logic              fmt_bad;
  logic              wait_load, wait_unit_ms, wait_expired;
  logic [WAIT_W-1:0] wait_amount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  dispbridge_step_rom #(
    .LANE_W (LANE_W),
    .DIV_W  (DIV_W)
  ) u_rom (
    .step        (step),
    .pclk_ref    (pclk_ref),
    .hsync_len   (hsync_len),
    .vsync_len   (vsync_len),
    .hback_len   (hback_len),
    .vback_len   (vback_len),
    .hfront_len  (hfront_len),
    .vfront_len  (vfront_len),
    .h_active    (h_active),
    .v_active    (v_active),
    .color_depth (color_depth),
    .loose_pack  (loose_pack),
    .lane_count  (lane_count),
    .pll_word    (pll_word),
    .lp_div      (lp_div),
    .addr        (rom_addr),
    .data        (rom_data),
    .fmt_bad     (fmt_bad)
  );

  dispbridge_waiter #(
    .CYCLES_PER_US (CYCLES_PER_US),
    .US_PER_MS     (US_PER_MS),
    .AMT_W         (WAIT_W)
  ) u_waiter (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (wait_load),
    .unit_ms (wait_unit_ms),
    .amount  (wait_amount),
    .expired (wait_expired)
  );

  dispbridge_ctrl #(
    .RST_MS  (RST_MS),
    .LOCK_US (LOCK_US),
    .WAIT_W  (WAIT_W),
    .DLY_W   (DLY_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .verify_en      (verify_en),
    .sleep_delay_ms (sleep_delay_ms),
    .on_delay_ms    (on_delay_ms),
    .rom_addr       (rom_addr),
    .rom_data       (rom_data),
    .fmt_bad        (fmt_bad),
    .reg_done       (reg_done),
    .reg_rdata      (reg_rdata),
    .wait_expired   (wait_expired),
    .step           (step),
    .wait_load      (wait_load),
    .wait_unit_ms   (wait_unit_ms),
    .wait_amount    (wait_amount),
    .reg_req        (reg_req),
    .reg_we         (reg_we),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .bridge_rst_n   (bridge_rst_n),
    .ready          (ready),
    .error          (error)
  );

endmodule

// File: rtl/dispbridge_bringup_chk.sv
module dispbridge_bringup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_req,
  input logic        reg_we,
  input logic [7:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        reg_done,
  input logic        bridge_rst_n,
  input logic        ready,
  input logic        error
);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_done) |=> (reg_req && $stable(reg_addr) &&
                                $stable(reg_we) && $stable(reg_wdata)));

  assert_no_req_in_bridge_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_rst_n |-> !reg_req);

  assert_vmode_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == 8'hB6) |->
      (reg_wdata[3:2] == 2'b10 && reg_wdata[15:4] == 12'd0));

  assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  assert_quiet_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready || error) |-> !reg_req);

  assert_ready_bridge_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> bridge_rst_n);

  assert_error_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && error));

endmodule

bind dispbridge_bringup dispbridge_bringup_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_req      (reg_req),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_done     (reg_done),
  .bridge_rst_n (bridge_rst_n),
  .ready        (ready),
  .error        (error)
);

// File: tb/dispbridge_bringup_tb.sv
`timescale 1ns/1ps
module dispbridge_bringup_tb;

  localparam int CPU   = 2;
  localparam int UPM   = 5;
  localparam int RSTMS = 10;
  localparam int LOCKU = 500;
  localparam int T_RST  = RSTMS * UPM * CPU;
  localparam int T_LOCK = LOCKU * CPU;

  // stimulus / expected table
  localparam int NROW = 7;
  localparam int TB_DEPTH [NROW] = '{16, 18, 18, 24, 24, 16, 20};
  localparam int TB_LOOSE [NROW] = '{0, 0, 1, 0, 1, 1, 0};
  localparam int TB_LANES [NROW] = '{4, 1, 2, 3, 4, 1, 2};
  localparam int TB_PCLK  [NROW] = '{0, 1, 0, 1, 0, 0, 1};
  localparam int TB_VERIF [NROW] = '{1, 0, 1, 1, 0, 1, 0};
  localparam int TB_LAT   [NROW] = '{1, 2, 3, 1, 4, 2, 1};
  localparam int TB_OK    [NROW] = '{1, 1, 1, 1, 1, 1, 0};
  localparam int TB_B6    [NROW] = '{'h8, 'h9, 'hA, 'hB, 'hB, 'h8, 0};
  localparam int TB_CFG   [NROW] = '{'h342, 'h362, 'h342, 'h362, 'h342, 'h342, 'h362};

  logic        clk, rst_n;
  logic        verify_en, pclk_ref, loose_pack;
  logic [7:0]  hsync_len, vsync_len, hback_len, vback_len, hfront_len, vfront_len;
  logic [15:0] h_active, v_active, pll_word;
  logic [4:0]  color_depth;
  logic [2:0]  lane_count;
  logic [5:0]  lp_div;
  logic [7:0]  sleep_delay_ms, on_delay_ms;
  logic        reg_req, reg_we, reg_done;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        bridge_rst_n, ready, error;

  dispbridge_bringup #(
    .CYCLES_PER_US (CPU),
    .US_PER_MS     (UPM),
    .RST_MS        (RSTMS),
    .LOCK_US       (LOCKU)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .verify_en (verify_en), .pclk_ref (pclk_ref),
    .hsync_len (hsync_len), .vsync_len (vsync_len), .hback_len (hback_len),
    .vback_len (vback_len), .hfront_len (hfront_len), .vfront_len (vfront_len),
    .h_active (h_active), .v_active (v_active), .color_depth (color_depth),
    .loose_pack (loose_pack), .lane_count (lane_count), .pll_word (pll_word),
    .lp_div (lp_div), .sleep_delay_ms (sleep_delay_ms), .on_delay_ms (on_delay_ms),
    .reg_req (reg_req), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_done (reg_done), .reg_rdata (reg_rdata),
    .bridge_rst_n (bridge_rst_n), .ready (ready), .error (error)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bus model state
  int          lat = 1;
  int          m_cnt = 0;
  int          cur_start = 0;
  logic [7:0]  cur_addr;
  logic [15:0] id_val, cfg_val;
  int          n_log = 0;
  logic [7:0]  l_addr [32];
  logic        l_we   [32];
  logic [15:0] l_data [32];
  int          l_start[32];
  int          l_done [32];
  int          proto_bad = 0;
  int          low_cnt = 0, hi_cnt = 0;
  bit          seen_req = 0;

  // expected sequence
  int          n_exp;
  logic [7:0]  e_addr [32];
  logic        e_we   [32];
  logic [15:0] e_data [32];
  string       e_tag  [32];
  int          exp_ok, exp_b6, exp_cfg;

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(1'b0, "WDOG", "watchdog expired", 32'(cyc), 32'd150000);
        summary_and_end();
      end
    end
  end

  // register access master model and pin monitor, acting on falling edges
  initial begin
    reg_done  = 1'b0;
    reg_rdata = '0;
    cur_addr  = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        reg_done = 1'b0;
        m_cnt = 0;
      end else if (reg_done) begin
        reg_done = 1'b0;
        m_cnt = 0;
      end else if (reg_req) begin
        if (m_cnt == 0) begin
          cur_start = cyc;
          cur_addr  = reg_addr;
        end else if (reg_addr != cur_addr) begin
          proto_bad++;
        end
        m_cnt++;
        if (m_cnt >= lat) begin
          reg_done  = 1'b1;
          reg_rdata = reg_we ? 16'h0 :
                      (reg_addr == 8'hB0) ? id_val :
                      (reg_addr == 8'hB7) ? cfg_val : 16'h0;
          if (n_log < 32) begin
            l_addr[n_log]  = reg_addr;
            l_we[n_log]    = reg_we;
            l_data[n_log]  = reg_wdata;
            l_start[n_log] = cur_start;
            l_done[n_log]  = cyc;
          end
          n_log++;
        end
      end
      if (rst_n && !bridge_rst_n) low_cnt++;
      if (rst_n && bridge_rst_n && !seen_req) hi_cnt++;
      if (reg_req) seen_req = 1'b1;
    end
  end

  task automatic push(input logic [7:0] a, input logic w, input logic [15:0] d,
                      input string t);
    e_addr[n_exp] = a;
    e_we[n_exp]   = w;
    e_data[n_exp] = d;
    e_tag[n_exp]  = t;
    n_exp++;
  endtask

  task automatic build_expected();
    n_exp = 0;
    if (verify_en) begin
      push(8'hB0, 1'b0, 16'h0, "R2");
      push(8'hB7, 1'b0, 16'h0, "R2");
    end
    push(8'hB1, 1'b1, {vsync_len, hsync_len}, "R3");
    push(8'hB2, 1'b1, {8'(vsync_len + vback_len), 8'(hsync_len + hback_len)}, "R3");
    push(8'hB3, 1'b1, {vfront_len, hfront_len}, "R3");
    push(8'hB4, 1'b1, h_active, "R3");
    push(8'hB5, 1'b1, v_active, "R3");
    if (exp_ok == 0) return;
    push(8'hB6, 1'b1, 16'(exp_b6), "R4");
    push(8'hDE, 1'b1, 16'(lane_count) - 16'd1, "R5");
    push(8'hB7, 1'b1, 16'(exp_cfg), "R6");
    push(8'hBA, 1'b1, pll_word, "R7");
    push(8'hB8, 1'b1, 16'h0, "R7");
    push(8'hBB, 1'b1, 16'(lp_div), "R7");
    push(8'hB9, 1'b1, 16'h1, "R7");
    push(8'hBC, 1'b1, 16'h1, "R8");
    push(8'hBF, 1'b1, 16'h11, "R8");
    push(8'hBC, 1'b1, 16'h1, "R8");
    push(8'hBF, 1'b1, 16'h29, "R8");
    push(8'hB7, 1'b1, 16'(exp_cfg) | 16'h0009, "R9");
  endtask

  task automatic run_seq();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_log = 0;
    low_cnt = 0;
    hi_cnt = 0;
    seen_req = 1'b0;
    proto_bad = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (ready || error) break;
    end
    chk(ready || error, "R9", "sequence finished", {30'd0, ready, error}, 32'h2);
    repeat (30) @(negedge clk);
  endtask

  task automatic check_log();
    build_expected();
    chk(n_log == n_exp, (exp_ok != 0) ? "R9" : "R4", "transfer count",
        32'(n_log), 32'(n_exp));
    for (int i = 0; i < n_exp && i < n_log && i < 32; i++) begin
      chk(l_addr[i] == e_addr[i] && l_we[i] == e_we[i] &&
          (!e_we[i] || l_data[i] == e_data[i]), e_tag[i],
          $sformatf("transfer %0d {we,addr,data}", i),
          {7'd0, l_we[i], l_addr[i], l_data[i]},
          {7'd0, e_we[i], e_addr[i], e_data[i]});
    end
    if (exp_ok != 0)
      chk(ready && !error, "R11", "ready set, error clear", {30'd0, ready, error}, 32'h2);
    else
      chk(error && !ready, "R4", "error set, ready clear", {30'd0, ready, error}, 32'h1);
    chk(proto_bad == 0, "R10", "request changed before done", 32'(proto_bad), 32'd0);
  endtask

  task automatic set_defaults();
    verify_en = 1'b1; pclk_ref = 1'b0; loose_pack = 1'b0;
    hsync_len = 8'd10; vsync_len = 8'd2; hback_len = 8'd40; vback_len = 8'd14;
    hfront_len = 8'd20; vfront_len = 8'd6;
    h_active = 16'd800; v_active = 16'd480;
    color_depth = 5'd24; lane_count = 3'd4; pll_word = 16'h4123; lp_div = 6'd5;
    sleep_delay_ms = 8'd3; on_delay_ms = 8'd2;
    id_val = 16'h2828; cfg_val = 16'h0301; lat = 1;
    exp_ok = 1; exp_b6 = 'hB; exp_cfg = 'h342;
  endtask

  initial begin
    rst_n = 1'b0;
    set_defaults();
    repeat (4) @(negedge clk);

    // reset state
    chk(!bridge_rst_n, "R1", "bridge reset low in reset", {31'd0, bridge_rst_n}, 32'd0);
    chk(!reg_req, "R1", "no request in reset", {31'd0, reg_req}, 32'd0);
    chk(!ready && !error, "R11", "flags low in reset", {30'd0, ready, error}, 32'd0);

    // table of configurations
    for (int r = 0; r < NROW; r++) begin
      set_defaults();
      color_depth = 5'(TB_DEPTH[r]);
      loose_pack  = TB_LOOSE[r][0];
      lane_count  = 3'(TB_LANES[r]);
      pclk_ref    = TB_PCLK[r][0];
      verify_en   = TB_VERIF[r][0];
      lat         = TB_LAT[r];
      exp_ok      = TB_OK[r];
      exp_b6      = TB_B6[r];
      exp_cfg     = TB_CFG[r];
      pll_word    = 16'h4000 + 16'(r * 17);
      lp_div      = 6'(r + 1);
      run_seq();
      check_log();
    end

    // R1 / R7 / R8 timing with a zero display-on pause
    set_defaults();
    verify_en = 1'b0;
    sleep_delay_ms = 8'd2;
    on_delay_ms = 8'd0;
    run_seq();
    check_log();
    chk(low_cnt >= T_RST && low_cnt <= T_RST + 6, "R1", "bridge reset low cycles",
        32'(low_cnt), 32'(T_RST));
    chk(hi_cnt >= T_RST && hi_cnt <= T_RST + 6, "R1", "quiet cycles after reset release",
        32'(hi_cnt), 32'(T_RST));
    if (n_log >= 17) begin
      chk(l_start[12] - l_done[11] >= T_LOCK && l_start[12] - l_done[11] <= T_LOCK + 6,
          "R7", "PLL lock wait cycles", 32'(l_start[12] - l_done[11]), 32'(T_LOCK));
      chk(l_start[14] - l_done[13] >= 2 * UPM * CPU &&
          l_start[14] - l_done[13] <= 2 * UPM * CPU + 6,
          "R8", "wake pause cycles", 32'(l_start[14] - l_done[13]), 32'(2 * UPM * CPU));
      chk(l_start[16] - l_done[15] <= 5, "R8", "zero display-on pause",
          32'(l_start[16] - l_done[15]), 32'd2);
    end else begin
      chk(1'b0, "R8", "timing run transfer count", 32'(n_log), 32'd17);
    end

    // porch sums past 255 wrap within their byte
    set_defaults();
    hsync_len = 8'd200; hback_len = 8'd100; vsync_len = 8'd250; vback_len = 8'd10;
    run_seq();
    check_log();
    chk(n_log > 3 && l_data[3] == 16'h042C, "R3", "wrapped porch sums",
        32'(l_data[3]), 32'h042C);

    // identity mismatch
    set_defaults();
    id_val = 16'h2827;
    run_seq();
    chk(n_log == 1, "R2", "stop after identity mismatch", 32'(n_log), 32'd1);
    chk(error && !ready, "R2", "error after identity mismatch", {30'd0, ready, error}, 32'h1);

    // power-on configuration mismatch
    set_defaults();
    cfg_val = 16'h0303;
    lat = 2;
    run_seq();
    chk(n_log == 2, "R2", "stop after config mismatch", 32'(n_log), 32'd2);
    chk(error && !ready, "R11", "error after config mismatch", {30'd0, ready, error}, 32'h1);

    summary_and_end();
  end

endmodule